// File: doc/BRIEF.md
# Match-Controlled Timer Counter

The block is a count engine with a programmable prescale stage and four compare channels. Software reaches it through a single-cycle register port. The port holds an enable and a self-clearing restart request, a count-source select, a prescale limit, the live count, the per-channel action bits, the compare values, a raw flag register and a write-one-to-clear register. The count source is either every clock cycle or falling edges on an external event pin. That pin is synchronised inside the block.

Each channel compares its value with the live count while counting is enabled. On a hit it can latch a flag, send the count back to zero, or freeze the count and drop the enable bit, in any combination. The block also exports one match line per channel for pin-shaping logic outside it.

Register word addresses are fixed as follows:

| Address | Register |
|---|---|
| 0 | control |
| 1 | count |
| 2 | prescale limit |
| 3 | mode |
| 4 | action bits |
| 6 | flags (read-only) |
| 7 | clear (write-only) |
| 8 + n | compare value of channel n |

Top module: `mtc_core`

## Requirements
- R1: With control bit 0 (enable) at 0, neither the count nor the prescale counter changes. After reset, control, count and flags all read 0.
- R2: Writing 1 to control bit 1 zeroes the count and the prescale counter on the following clock edge. That bit then reads 0 again without any further write.
- R3: With mode 0 (timer), the count advances once every (prescale limit + 1) enabled clock cycles.
- R4: With mode 2 (event), the count advances only on falling edges of `evt_i`, after a two-flop synchroniser. Rising edges, steady levels and clock cycles do not advance it. The prescale limit divides the edges in the same way it divides clock cycles in R3.
- R5: When action bit 3n+1 is set and the enabled count equals compare value n, the count reads 0 on the next cycle. It then runs again, giving a period of value+1.
- R6: When action bit 3n+2 is set and the enabled count equals compare value n, the count freezes at that value and control bit 0 clears.
- R7: When action bit 3n is set, a match on channel n sets flag bit n in the flag register. Without that bit, the flag stays 0.
- R8: Writing 1 to bit n of the clear register clears flag n, and writing 0 leaves it alone. If a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R9: A write to the count register loads that value, and a read returns the live count.
- R10: `match_o[n]` is high in exactly those cycles in which counting is enabled and the count equals compare value n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Read data for `reg_addr_i`, combinational |
| evt_i | input | 1 | External event input, asynchronous |
| match_o | output | N_MATCH | Per-channel match lines |

## Verification
Two events can land on one flag in the same cycle: a hardware match setting it and a software clear removing it. The bench provokes this with a large prescale limit, which holds the count on the compare value for eight cycles. It polls `match_o` and issues the clear on the very next edge, while the match is still live. The flag must still read 1 right after that edge, and it must drop to 0 once counting is disabled and the clear is repeated. A second overlap occurs when reset-on-match and stop-on-match both act on the same hit. The bench judges that case from the frozen count and from the cleared enable bit.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd1;
  localparam logic [ADDR_W-1:0] A_PRESC = 4'd2;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd3;
  localparam logic [ADDR_W-1:0] A_ACT   = 4'd4;
  localparam logic [ADDR_W-1:0] A_FLAG  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CLR   = 4'd7;
  localparam int unsigned       A_CMP0  = 8;

  localparam logic [1:0] MODE_TIMER = 2'd0;
  localparam logic [1:0] MODE_EVENT = 2'd2;

  // per-channel action bits: irq at 3n, restart at 3n+1, halt at 3n+2
  typedef struct packed {
    logic halt;
    logic restart;
    logic irq;
  } mact_t;
endpackage

// File: rtl/mtc_edge_sync.sv
module mtc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];

  // a single falling edge produces a one-cycle pulse
  p_fall_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/mtc_count_core.sv
module mtc_count_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             srst_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             mclr_i,
  input  logic [CNT_W-1:0] presc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] tc_q, pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q <= '0;
      pc_q <= '0;
    end else if (srst_i) begin
      tc_q <= '0;
      pc_q <= '0;
    end else if (load_i) begin
      tc_q <= load_val_i;
      pc_q <= '0;
    end else if (mclr_i) begin
      tc_q <= '0;
      pc_q <= '0;
    end else if (en_i && tick_i) begin
      if (pc_q >= presc_i) begin
        pc_q <= '0;
        tc_q <= tc_q + 1'b1;
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  assign count_o = tc_q;

  p_hold_disabled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !srst_i && !load_i && !mclr_i) |=> ($stable(tc_q) && $stable(pc_q)));
  p_srst_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (tc_q == '0 && pc_q == '0));
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !srst_i && !load_i && !mclr_i && pc_q >= presc_i)
      |=> tc_q == $past(tc_q) + 1'b1);
  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mclr_i && !load_i) |=> tc_q == '0);
endmodule

// File: rtl/mtc_match_unit.sv
module mtc_match_unit #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N     = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [CNT_W-1:0]          count_i,
  input  logic [N-1:0][CNT_W-1:0]   cmp_i,
  input  mtc_pkg::mact_t [N-1:0]    act_i,
  input  logic [N-1:0]              ack_i,
  output logic [N-1:0]              hit_o,
  output logic [N-1:0]              flag_o,
  output logic                      restart_o,
  output logic                      halt_o
);
  logic [N-1:0] restart_v, halt_v, flag_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    logic set_w;
    assign hit_o[g]     = en_i && (count_i == cmp_i[g]);
    assign set_w        = hit_o[g] && act_i[g].irq;
    assign restart_v[g] = hit_o[g] && act_i[g].restart;
    assign halt_v[g]    = hit_o[g] && act_i[g].halt;

    // set beats clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= (flag_q[g] & ~ack_i[g]) | set_w;
    end

    p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_o[g] && act_i[g].irq) |=> flag_q[g]);
    p_flag_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[g] && !(hit_o[g] && act_i[g].irq)) |=> !flag_q[g]);
    p_flag_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[g] && !ack_i[g]) |=> flag_q[g]);
  end

  assign restart_o = |restart_v;
  assign halt_o    = |halt_v;
  assign flag_o    = flag_q;
endmodule

// File: rtl/mtc_core.sv
module mtc_core #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned N_MATCH     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       reg_we_i,
  input  logic [mtc_pkg::ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]           reg_wdata_i,
  output logic [CNT_W-1:0]           reg_rdata_o,
  input  logic                       evt_i,
  output logic [N_MATCH-1:0]         match_o
);
  import mtc_pkg::*;

  localparam int unsigned ACT_W = 3 * N_MATCH;

  logic                         en_q, srst_q;
  logic [1:0]                   mode_q;
  logic [CNT_W-1:0]             presc_q;
  mact_t [N_MATCH-1:0]          act_q;
  logic [N_MATCH-1:0][CNT_W-1:0] cmp_q;

  logic             ctrl_we, count_we, evt_fall, tick;
  logic             restart, halt;
  logic [CNT_W-1:0] count;
  logic [N_MATCH-1:0] flags, ack;

  assign ctrl_we  = reg_we_i && reg_addr_i == A_CTRL;
  assign count_we = reg_we_i && reg_addr_i == A_COUNT;
  assign ack      = (reg_we_i && reg_addr_i == A_CLR) ? reg_wdata_i[N_MATCH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      srst_q  <= 1'b0;
      mode_q  <= MODE_TIMER;
      presc_q <= '0;
      act_q   <= '0;
    end else begin
      srst_q <= ctrl_we && reg_wdata_i[1];
      if (halt)         en_q <= 1'b0;
      else if (ctrl_we) en_q <= reg_wdata_i[0];
      if (reg_we_i && reg_addr_i == A_MODE)  mode_q  <= reg_wdata_i[1:0];
      if (reg_we_i && reg_addr_i == A_PRESC) presc_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == A_ACT)   act_q   <= reg_wdata_i[ACT_W-1:0];
    end
  end

  for (genvar g = 0; g < N_MATCH; g++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmp_q[g] <= '0;
      else if (reg_we_i && reg_addr_i == ADDR_W'(A_CMP0 + g)) cmp_q[g] <= reg_wdata_i;
    end
  end

  mtc_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .async_i(evt_i), .fall_o(evt_fall)
  );

  assign tick = (mode_q == MODE_EVENT) ? evt_fall : 1'b1;

  mtc_count_core #(.CNT_W(CNT_W)) i_count (
    .clk_i, .rst_ni,
    .en_i(en_q && !halt), .tick_i(tick), .srst_i(srst_q),
    .load_i(count_we), .load_val_i(reg_wdata_i),
    .mclr_i(restart), .presc_i(presc_q), .count_o(count)
  );

  mtc_match_unit #(.CNT_W(CNT_W), .N(N_MATCH)) i_match (
    .clk_i, .rst_ni, .en_i(en_q), .count_i(count), .cmp_i(cmp_q),
    .act_i(act_q), .ack_i(ack), .hit_o(match_o), .flag_o(flags),
    .restart_o(restart), .halt_o(halt)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = CNT_W'({srst_q, en_q});
      A_COUNT: reg_rdata_o = count;
      A_PRESC: reg_rdata_o = presc_q;
      A_MODE:  reg_rdata_o = CNT_W'(mode_q);
      A_ACT:   reg_rdata_o = CNT_W'(act_q);
      A_FLAG:  reg_rdata_o = CNT_W'(flags);
      default: ;
    endcase
    for (int i = 0; i < N_MATCH; i++)
      if (reg_addr_i == ADDR_W'(A_CMP0 + i)) reg_rdata_o = cmp_q[i];
  end

  p_srst_selfclear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_q && !(ctrl_we && reg_wdata_i[1])) |=> !srst_q);
  p_halt_drops_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |=> !en_q);
  p_halt_freezes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !restart && !srst_q && !count_we) |=> $stable(count));
  p_match_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> match_o == '0);
endmodule

// File: tb/test_mtc_core.sv
`timescale 1ns/1ps
module test_mtc_core;
  import mtc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        evt = 1'b0;
  logic [3:0]  match;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mtc_core i_mtc_core (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt), .match_o(match)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic restart_cnt();
    wr(A_CTRL, 32'h2);
    @(negedge clk);
  endtask

  task automatic park_cmps();
    for (int k = 0; k < 4; k++) wr(4'(A_CMP0 + k), 32'd1000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl after reset", v, 0);
    rd(A_COUNT, v); chk("R1 count after reset", v, 0);
    rd(A_FLAG, v);  chk("R1 flags after reset", v, 0);
    chk("R10 match lines after reset", 32'(match), 0);

    park_cmps();

    // R3 timer sweep over prescale limits, R1 hold while disabled
    for (int pr = 0; pr < 4; pr++) begin
      int k;
      k = 7 + pr * 5;
      restart_cnt();
      wr(A_PRESC, 32'(pr));
      wr(A_ACT, 0);
      wr(A_CTRL, 32'h1);
      repeat (k) @(negedge clk);
      rd(A_COUNT, v);
      chk($sformatf("R3 timer count pr=%0d", pr), v, 32'(k / (pr + 1)));
      wr(A_CTRL, 32'h0);
      rd(A_COUNT, v);
      repeat (10) @(negedge clk);
      rd(A_COUNT, v2);
      chk("R1 count holds while disabled", v2, v);
    end

    // R2 restart clears prescale counter too
    restart_cnt();
    wr(A_PRESC, 32'd3);
    wr(A_CTRL, 32'h1);
    @(negedge clk);
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, v);  chk("R2 restart bit pending", v, 32'h2);
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, v);  chk("R2 restart bit self-clears", v, 32'h1);
    rd(A_COUNT, v); chk("R2 count zeroed", v, 0);
    repeat (3) @(negedge clk);
    rd(A_COUNT, v); chk("R2 prescale zeroed, 3 ticks", v, 0);
    @(negedge clk);
    rd(A_COUNT, v); chk("R2 prescale zeroed, 4 ticks", v, 1);
    wr(A_CTRL, 32'h0);

    // R9 load and live read
    wr(A_PRESC, 0);
    wr(A_COUNT, 32'h1234);
    rd(A_COUNT, v); chk("R9 loaded value", v, 32'h1234);
    wr(A_CTRL, 32'h1);
    repeat (5) @(negedge clk);
    rd(A_COUNT, v); chk("R9 live count", v, 32'h1234 + 5);
    restart_cnt();

    // R5/R10 restart on match, per channel
    for (int n = 0; n < 4; n++) begin
      int m, k, seen, exp_seen, other;
      m = 3 + n; k = 20 + n; seen = 0; exp_seen = 0; other = 0;
      restart_cnt();
      wr(4'(A_CMP0 + n), 32'(m));
      wr(A_ACT, 32'(1) << (3 * n + 1));
      wr(A_CTRL, 32'h1);
      for (int t = 1; t <= k; t++) begin
        @(negedge clk);
        if (match[n]) seen++;
        if ((match & ~(4'(1) << n)) != 0) other++;
        if (t % (m + 1) == m) exp_seen++;
      end
      rd(A_COUNT, v);
      chk($sformatf("R5 restart period ch%0d", n), v, 32'(k % (m + 1)));
      chk($sformatf("R10 match cycles ch%0d", n), 32'(seen), 32'(exp_seen));
      chk("R10 other channels quiet", 32'(other), 0);
      rd(A_FLAG, v);  chk("R7 no flag without irq bit", v, 0);
      restart_cnt();
      wr(4'(A_CMP0 + n), 32'd1000);
    end

    // R6 halt + R7 flag + R8 clear
    for (int n = 0; n < 4; n++) begin
      int m;
      m = 5 + n;
      restart_cnt();
      wr(4'(A_CMP0 + n), 32'(m));
      wr(A_ACT, 32'(5) << (3 * n));
      wr(A_CTRL, 32'h1);
      repeat (30) @(negedge clk);
      rd(A_COUNT, v); chk($sformatf("R6 frozen count ch%0d", n), v, 32'(m));
      rd(A_CTRL, v);  chk("R6 enable cleared", v, 0);
      rd(A_FLAG, v);  chk("R7 flag set", v, 32'(1) << n);
      wr(A_CLR, 32'hF & ~(32'(1) << n));
      rd(A_FLAG, v);  chk("R8 zero bits no effect", v, 32'(1) << n);
      wr(A_CLR, 32'(1) << n);
      rd(A_FLAG, v);  chk("R8 flag cleared", v, 0);
      wr(4'(A_CMP0 + n), 32'd1000);
    end

    // R6 with restart on the same channel: count goes to 0, enable drops
    restart_cnt();
    wr(A_CMP0, 32'd4);
    wr(A_ACT, 32'h6);
    wr(A_CTRL, 32'h1);
    repeat (20) @(negedge clk);
    rd(A_COUNT, v); chk("R6 restart+halt count", v, 0);
    rd(A_CTRL, v);  chk("R6 restart+halt enable", v, 0);
    wr(A_CMP0, 32'd1000);

    // R8 set and clear in the same cycle
    restart_cnt();
    wr(A_PRESC, 32'd7);
    wr(A_CMP0, 32'd2);
    wr(A_ACT, 32'h1);
    wr(A_CTRL, 32'h1);
    for (int t = 0; t < 100 && !match[0]; t++) @(negedge clk);
    chk("R10 match reached", 32'(match[0]), 1);
    wr(A_CLR, 32'h1);
    rd(A_FLAG, v);  chk("R8 set wins over clear", v, 32'h1);
    wr(A_CTRL, 32'h0);
    wr(A_CLR, 32'h1);
    rd(A_FLAG, v);  chk("R8 clear after match gone", v, 0);
    wr(A_CMP0, 32'd1000);
    wr(A_ACT, 0);

    // R4 event mode
    wr(A_MODE, 32'(MODE_EVENT));
    for (int pr = 0; pr < 2; pr++) begin
      for (int e = 3; e <= 5; e += 2) begin
        restart_cnt();
        wr(A_PRESC, 32'(pr));
        wr(A_CTRL, 32'h1);
        repeat (10) @(negedge clk);
        rd(A_COUNT, v); chk("R4 no clock counting", v, 0);
        for (int i = 0; i < e; i++) begin
          @(negedge clk); evt = 1'b1;
          repeat (3) @(negedge clk);
          if (i == 0) begin
            repeat (4) @(negedge clk);
            rd(A_COUNT, v); chk("R4 rising edge ignored", v, 0);
          end
          evt = 1'b0;
          repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rd(A_COUNT, v);
        chk($sformatf("R4 event count e=%0d pr=%0d", e, pr), v, 32'(e / (pr + 1)));
      end
    end
    restart_cnt();
    wr(A_MODE, 32'(MODE_TIMER));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule